// File: doc/BRIEF.md
# I2S Stereo Sample Serializer

This block puts one 16-bit two's-complement sample per channel onto an I2S serial data line. The bit clock and the word select come from outside, and the block runs in its own system clock domain. The receive-path sample goes out in the slot where word select is low (left). The transmit-path sample goes out in the slot where word select is high (right). The block makes no clock of its own and makes no attempt to match its rate to the input side: the word-select rate must equal the input side's rate, but the two need no phase relation.

Each channel has a holding register that is written from a parallel word with a one-cycle load strobe. A holding register is copied into the serial shifter when that channel's slot begins. A load that lands after the slot has begun is therefore sent in the channel's next slot. If no new load arrives, the last value is sent again. The slot length follows the word-select period and is not fixed. A short slot carries only the top bits of the word. A long slot is padded with zeros after the last bit.

Both external timing inputs pass through synchronizers. The block reacts to bit clock edges as they appear in the system clock domain, so the bit clock must be several times slower than the system clock.

Top module: `i2s_pcm_serializer`

## Requirements
- R1: The serial data output changes only in the system cycle that follows a detected falling bit clock edge. It holds its value through the rest of the bit period, including the rising edge.
- R2: When word select is 1 (right slot), the slot carries the transmit-path holding register.
- R3: A slot begins at the first falling bit clock edge after the edge where word select toggled. On that edge the MSB (bit 15) is driven, and the following falling edges drive bits 14 down to 0. When word select is 0 (left slot), the slot carries the receive-path holding register.
- R4: A slot of L < 16 bit periods carries bits 15 down to 16-L. The next slot starts with its own MSB, with no carry-over.
- R5: In a slot longer than 16 bit periods, every bit after bit 0 is 0.
- R6: A load pulse writes the channel's holding register on the next clock. A slot sends the value held when it began. Loads made later go to that channel's next slot. Without a load, the previous value is repeated.
- R7: While the active-low reset is asserted, the data output is 0. Reset also clears both holding registers, so slots sent before any load carry all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bit_clk | input | 1 | External I2S bit clock, asynchronous |
| word_sel | input | 1 | External word select, 0 = left/receive, 1 = right/transmit |
| rx_sample | input | 16 | Receive-path sample for the left slot |
| rx_load | input | 1 | One-cycle strobe that writes rx_sample |
| tx_sample | input | 16 | Transmit-path sample for the right slot |
| tx_load | input | 1 | One-cycle strobe that writes tx_sample |
| ser_data | output | 1 | Serial data, updated after falling bit clock edges |

## Verification
A falling bit clock edge reaches the data output SYNC_STAGES+1 system clocks after the pin changes: the synchronizer stages, then the output register. A load appears in the holding register one clock after its strobe. The bench holds each bit clock phase for six system clocks. It compares each bit one clock before the rising edge, which is well after the output has settled. It compares the same bit again one clock before the next falling edge, which shows that the value held across the rise. Loads are issued only in the high phase, away from both edges, so a load that belongs to the current slot and one that belongs to the next slot cannot be confused.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

   localparam int NUM_CH = 2;

   typedef struct packed {
      logic  rise;
      logic  fall;
      logic  start;
      chan_e chan;
   } bclk_evt_t;

endpackage

// File: rtl/i2stx_sync.sv
module i2stx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2stx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/i2stx_slot_track.sv
module i2stx_slot_track
   import i2stx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bclk_i,
   input  logic      ws_i,
   output bclk_evt_t evt_o
);

   logic bclk_s, ws_s;
   logic bclk_q;
   logic ws_cur_q;
   logic pend_q;
   logic rise_w, fall_w;

   i2stx_sync #(.STAGES(SYNC_STAGES)) u_sync_bclk (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (bclk_i),
      .q_o   (bclk_s)
   );

   i2stx_sync #(.STAGES(SYNC_STAGES)) u_sync_ws (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ws_i),
      .q_o   (ws_s)
   );

   assign rise_w = bclk_s & ~bclk_q;
   assign fall_w = ~bclk_s & bclk_q;

   // Word select is sampled at rising edges, where it is stable; a change
   // arms a slot start that fires on the next falling edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q   <= 1'b0;
         ws_cur_q <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         bclk_q <= bclk_s;
         if (rise_w) begin
            pend_q   <= (ws_s != ws_cur_q);
            ws_cur_q <= ws_s;
         end else if (fall_w) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign evt_o.rise  = rise_w;
   assign evt_o.fall  = fall_w;
   assign evt_o.start = fall_w & pend_q;
   assign evt_o.chan  = chan_e'(ws_cur_q);

   // checker state: starts seen since word select last changed level
   logic [1:0] starts_in_lvl_q;
   logic       ws_lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         starts_in_lvl_q <= '0;
         ws_lvl_q        <= 1'b0;
      end else begin
         ws_lvl_q <= ws_s;
         if (ws_s != ws_lvl_q) begin
            starts_in_lvl_q <= '0;
         end else if (evt_o.start && starts_in_lvl_q != 2'd3) begin
            starts_in_lvl_q <= starts_in_lvl_q + 2'd1;
         end
      end
   end

   // R3
   one_start_per_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o.start |-> (starts_in_lvl_q == 2'd0));

endmodule

// File: rtl/i2stx_hold.sv
module i2stx_hold #(
   parameter int W   = 16,
   parameter int NCH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [NCH-1:0] load_i,
   input  logic [W-1:0] data_i [NCH],
   output logic [W-1:0] held_o [NCH]
);

   if (NCH < 1) begin : g_bad_nch
      $error("i2stx_hold: NCH must be at least 1");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held_o[c] <= '0;
         end else if (load_i[c]) begin
            held_o[c] <= data_i[c];
         end
      end

      // R6
      load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
         load_i[c] |=> (held_o[c] == $past(data_i[c])));

      // R6
      no_load_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !load_i[c] |=> $stable(held_o[c]));
   end

endmodule

// File: rtl/i2stx_shifter.sv
module i2stx_shifter
   import i2stx_pkg::*;
#(
   parameter int W   = 16,
   parameter int NCH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  bclk_evt_t    evt_i,
   input  logic [W-1:0] held_i [NCH],
   output logic         sdata_o
);

   localparam int CNT_W = $clog2(W + 2);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(W + 1);
   localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(W);

   if (W < 2) begin : g_bad_w
      $error("i2stx_shifter: W must be at least 2");
   end

   logic [W-1:0] word_w;
   logic [W-1:0] shreg_q;

   assign word_w = held_i[int'(evt_i.chan)];

   // zero fill into the shifter makes long slots pad with 0 and lets a new
   // start simply overwrite a partly sent short slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         sdata_o <= 1'b0;
      end else if (evt_i.fall) begin
         if (evt_i.start) begin
            sdata_o <= word_w[W-1];
            shreg_q <= {word_w[W-2:0], 1'b0};
         end else begin
            sdata_o <= shreg_q[W-1];
            shreg_q <= {shreg_q[W-2:0], 1'b0};
         end
      end
   end

   // checker state: bits driven since the last slot start (saturating)
   logic [CNT_W-1:0] sent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sent_q <= CNT_SAT;
      end else if (evt_i.fall) begin
         if (evt_i.start) begin
            sent_q <= CNT_W'(1);
         end else if (sent_q != CNT_SAT) begin
            sent_q <= sent_q + CNT_W'(1);
         end
      end
   end

   // R1
   out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_i.fall |=> $stable(sdata_o));

   // R5
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i.fall && !evt_i.start && sent_q >= CNT_LIM) |=> !sdata_o);

   // R7
   reset_low_chk: assert property (@(posedge clk)
      !rst_n |=> !sdata_o);

endmodule

// File: rtl/i2s_pcm_serializer.sv
module i2s_pcm_serializer
   import i2stx_pkg::*;
#(
   parameter int SAMPLE_W    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_clk,
   input  logic                word_sel,
   input  logic [SAMPLE_W-1:0] rx_sample,
   input  logic                rx_load,
   input  logic [SAMPLE_W-1:0] tx_sample,
   input  logic                tx_load,
   output logic                ser_data
);

   if (SAMPLE_W < 2) begin : g_bad_sample_w
      $error("i2s_pcm_serializer: SAMPLE_W must be at least 2");
   end

   bclk_evt_t           evt;
   logic [NUM_CH-1:0]   load_v;
   logic [SAMPLE_W-1:0] data_a [NUM_CH];
   logic [SAMPLE_W-1:0] held_a [NUM_CH];

   // channel index 0 = left (receive path), 1 = right (transmit path)
   assign load_v[int'(CH_LEFT)]  = rx_load;
   assign load_v[int'(CH_RIGHT)] = tx_load;
   assign data_a[int'(CH_LEFT)]  = rx_sample;
   assign data_a[int'(CH_RIGHT)] = tx_sample;

   i2stx_slot_track #(.SYNC_STAGES(SYNC_STAGES)) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .bclk_i (bit_clk),
      .ws_i   (word_sel),
      .evt_o  (evt)
   );

   i2stx_hold #(.W(SAMPLE_W), .NCH(NUM_CH)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_v),
      .data_i (data_a),
      .held_o (held_a)
   );

   i2stx_shifter #(.W(SAMPLE_W), .NCH(NUM_CH)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt),
      .held_i  (held_a),
      .sdata_o (ser_data)
   );

endmodule

// File: tb/i2s_pcm_serializer_test.sv
module i2s_pcm_serializer_test;

   localparam int SW = 16;
   localparam int H  = 6;   // system clocks per bit clock phase

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bclk = 1'b1;
   logic          ws = 1'b0;
   logic [SW-1:0] rx_d = '0, tx_d = '0;
   logic          rx_v = 1'b0, tx_v = 1'b0;
   logic          sd;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [SW-1:0] hold_m [2];
   bit            fresh [2];
   bit            late [2];
   logic [SW-1:0] prev_w;
   int            prev_L;
   bit            prev_ch, prev_f6;
   string         prev_force;

   always #4 clk = ~clk;

   i2s_pcm_serializer #(.SAMPLE_W(SW), .SYNC_STAGES(2)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_clk   (bclk),
      .word_sel  (ws),
      .rx_sample (rx_d),
      .rx_load   (rx_v),
      .tx_sample (tx_d),
      .tx_load   (tx_v),
      .ser_data  (sd)
   );

   function automatic bit bitk(input logic [SW-1:0] w, input int k);
      if (k >= 1 && k <= SW) return w[SW-k];
      return 1'b0;
   endfunction

   function automatic string tagf(input int k, input int L, input bit ch,
                                  input bit f6, input string force_tag);
      if (force_tag != "") return force_tag;
      if (k > SW) return "R5";
      if (f6) return "R6";
      if (L < SW) return "R4";
      if (ch) return "R2";
      return "R3";
   endfunction

   task automatic check(input bit got, input bit exp, input string tag, input string what);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, got, exp, $time);
      end
   endtask

   task automatic do_load(input bit ch, input logic [SW-1:0] v, input bit mid);
      @(negedge clk);
      if (ch) begin tx_d = v; tx_v = 1'b1; end
      else    begin rx_d = v; rx_v = 1'b1; end
      @(negedge clk);
      rx_v = 1'b0; tx_v = 1'b0;
      hold_m[ch] = v;
      fresh[ch]  = 1'b1;
      late[ch]   = mid;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bclk = 1'b1; ws = 1'b0;
      rx_v = 1'b0; tx_v = 1'b0;
      hold_m[0] = '0; hold_m[1] = '0;
      fresh[0] = 1'b0; fresh[1] = 1'b0; late[0] = 1'b0; late[1] = 1'b0;
      repeat (4) @(negedge clk);
      check(sd, 1'b0, "R7", "data low in reset");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      prev_w = '0; prev_L = 1; prev_ch = 1'b0; prev_f6 = 1'b0; prev_force = "R7";
   endtask

   // one slot of L bit periods on channel ch; a load of lv at period load_p
   task automatic slot(input bit ch, input int L, input int load_p,
                       input logic [SW-1:0] lv, input bit other_load,
                       input string force_tag);
      logic [SW-1:0] cw;
      bit f6;
      bit exp;
      string tg;
      cw = '0; f6 = 1'b0;
      for (int p = 0; p < L; p++) begin
         @(negedge clk);
         bclk = 1'b0;
         if (p == 0) ws = ch;
         repeat (H-1) @(negedge clk);
         if (p == 0) begin
            exp = bitk(prev_w, prev_L);
            tg  = tagf(prev_L, prev_L, prev_ch, prev_f6, prev_force);
         end else begin
            exp = bitk(cw, p);
            tg  = tagf(p, L, ch, f6, force_tag);
         end
         check(sd, exp, tg, "bit after falling edge");
         @(negedge clk);
         bclk = 1'b1;
         repeat (H-1) @(negedge clk);
         check(sd, exp, "R1", "bit held through high phase");
         if (p == load_p) do_load(ch, lv, p >= 1);
         if (other_load && p == L/2) do_load(!ch, SW'($urandom), 1'b0);
         if (p == 0) begin
            cw = hold_m[ch];
            f6 = !fresh[ch] || late[ch];
            fresh[ch] = 1'b0;
            late[ch]  = 1'b0;
         end
      end
      prev_w = cw; prev_L = L; prev_ch = ch; prev_f6 = f6; prev_force = force_tag;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      int L, lp;
      bit ch;
      void'($urandom(32'd20240611));
      do_reset();

      // R7: holding registers cleared, first slot sends zeros
      slot(1'b1, 16, -1, '0, 1'b0, "R7");
      slot(1'b0, 16, -1, '0, 1'b0, "R7");

      do_load(1'b0, 16'hA5C3, 1'b0);
      do_load(1'b1, 16'h8001, 1'b0);
      slot(1'b1, 16, -1, '0, 1'b0, "R2");   // right = transmit path
      slot(1'b0, 16, -1, '0, 1'b0, "R3");   // left = receive path, MSB first
      slot(1'b1, 8,  -1, '0, 1'b0, "");     // R4 short
      slot(1'b0, 24, -1, '0, 1'b0, "");     // R5 long
      slot(1'b1, 1,  -1, '0, 1'b0, "");     // R4 single bit
      slot(1'b0, 32, -1, '0, 1'b0, "");     // R5
      slot(1'b1, 16, -1, '0, 1'b0, "R2");
      // R6: load mid-slot goes to the next left slot
      slot(1'b0, 16, 5, 16'h1234, 1'b0, "");
      slot(1'b1, 16, -1, '0, 1'b0, "");     // R6 repeat
      slot(1'b0, 16, -1, '0, 1'b0, "");     // R6 late load now sent
      // R6: load in the period before the slot start counts now
      slot(1'b1, 16, 0, 16'h7FFE, 1'b0, "R6");
      slot(1'b0, 16, -1, '0, 1'b1, "");

      for (int i = 0; i < 50; i++) begin
         ch = (i % 2 == 0);
         L  = 1 + int'($urandom % 32);
         lp = ($urandom % 3 == 0) ? -1 : int'($urandom % L);
         slot(ch, L, lp, SW'($urandom), bit'($urandom % 2), "");
      end

      // R7: reset mid-stream clears both holding registers
      do_reset();
      slot(1'b1, 16, -1, '0, 1'b0, "R7");
      slot(1'b0, 20, -1, '0, 1'b0, "R7");
      do_load(1'b1, 16'hC0DE, 1'b0);
      slot(1'b1, 16, -1, '0, 1'b0, "R2");
      slot(1'b0, 12, -1, '0, 1'b0, "");

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule